// File: doc/BRIEF.md
# Packed Image-Buffer Address Mapper

This block sits between pixel streams and a set of independent 32-bit external memory banks. A write frame is a run of 8-bit pixels of one image, numbered from zero in arrival order and closed by a last-pixel flag. For each pixel the block works out a bank, a word address and a byte lane, and gathers pixels that share a word. It issues one masked word write per filled word, or a partial word when the frame closes. On the read side it turns an image number and a pixel index into a word read and picks the pixel's byte out of the returned word.

Four layouts can be selected at run time. They range from one pixel per word with one image per bank, to four consecutive pixels of one image per word. Each layout trades the number of banks in use against the number of bus cycles a frame costs. A running count of the cycles in which either bus port was used makes the layouts easy to compare. The layout may only be changed while no frame is in progress. An attempt made at any other time is dropped and recorded in a sticky error flag.

Top module: `pix_pack_mapper`

## Requirements
- R1: With layout code 0, the pixel of image i at index n goes to bank i, word address n, in byte lane 0 (bits 7:0), with byte enable 4'b0001.
- R2: With layout code 1, the pixel goes to bank i/4, word address n, in byte lane i mod 4, with only that lane's enable bit set.
- R3: With layout code 2, the pixel goes to bank i, word address n/4, in byte lane n mod 4. A word with all four enables set is issued after the pixel with n mod 4 = 3.
- R4: With layout code 3, the pixel goes to bank i/2, word address n/2, in byte lane 2*(i mod 2) + (n mod 2).
- R5: When the frame ends part-way through a word, that word is issued with enable bits only for the lanes that hold pixels of the frame.
- R6: A word appears on the write port for exactly one cycle, in the cycle after the pixel that completes it. No write is issued for a word that is still filling.
- R7: A read request appears on the read port as bank and word address in the next cycle. The memory returns the word in the cycle after that. In that cycle rd_pix_valid is high and rd_pix carries the byte of the addressed lane.
- R8: bus_cycles starts at 0 and rises by exactly one for each cycle in which the write port, the read port or both are active.
- R9: A layout request made while no frame is in progress and no pixel is presented takes effect for the following pixels. Reset selects layout code 0.
- R10: A layout request made while a frame is in progress or a pixel is presented is ignored and sets cfg_err. cfg_err stays set until reset.
- R11: After reset no write or read is issued, rd_pix_valid is low, cfg_err is low and bus_cycles is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Layout change request |
| cfg_layout | input | 2 | Requested layout code 0..3 |
| cfg_err | output | 1 | Sticky flag: a layout request was refused |
| wr_valid | input | 1 | Pixel presented on the write stream |
| wr_img | input | 3 | Image number, sampled on the first pixel of a frame |
| wr_pix | input | 8 | Pixel value |
| wr_last | input | 1 | Marks the final pixel of the frame |
| wq_valid | output | 1 | Word write issued this cycle |
| wq_bank | output | 3 | Bank of the write |
| wq_addr | output | 19 | Word address of the write |
| wq_be | output | 4 | Byte-lane enables of the write |
| wq_data | output | 32 | Write data |
| rd_valid | input | 1 | Pixel read request |
| rd_img | input | 3 | Image number of the read |
| rd_idx | input | 17 | Pixel index of the read |
| rq_valid | output | 1 | Word read issued this cycle |
| rq_bank | output | 3 | Bank of the read |
| rq_addr | output | 19 | Word address of the read |
| rq_rdata | input | 32 | Word returned the cycle after rq_valid |
| rd_pix_valid | output | 1 | rd_pix holds a returned pixel |
| rd_pix | output | 8 | Byte picked from the returned word |
| bus_cycles | output | 32 | Count of cycles with any bus access |

## Verification
On every cycle the assertions check these rules: the layout stays put while a frame or pixel is in flight, and the error flag never clears. Every issued write has at least one enable bit, in a valid bank. The single-lane layouts enable exactly one lane, and the paired layout keeps to one half of the word. Each read issue is followed by a returned pixel, and the cycle count rises exactly when a port is busy. Only the directed scenarios can show the address arithmetic and the lane placement for each layout. The same goes for the packing order inside a word, the trimmed enables of a partial final word, a refused mid-frame change leaving the mapping as it was, and overlapping write and read issues costing a single counted cycle.

// File: rtl/ppm_pkg.sv
// Shared types for the packed image-buffer address mapper.
// Assumes the layout code is a 2-bit value carried on the configuration port.
package ppm_pkg;
    typedef enum logic [1:0] {
        LAY_SEP  = 2'd0,  // one image per bank, one pixel per word
        LAY_LANE = 2'd1,  // four images share a word, one lane each
        LAY_QUAD = 2'd2,  // one image per bank, four pixels per word
        LAY_PAIR = 2'd3   // two images per bank, two pixels each per word
    } layout_e;
endpackage

// File: rtl/ppm_addr_map.sv
// Combinational translation of (layout, image, pixel index) into bank,
// word address and byte lane. Assumes four byte lanes per word.
module ppm_addr_map
    import ppm_pkg::*;
#(
    parameter int IMG_W  = 3,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 17,
    parameter int ADDR_W = 19,
    parameter int LANE_W = 2
) (
    input  layout_e           lay,
    input  logic [IMG_W-1:0]  img,
    input  logic [IDX_W-1:0]  idx,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] lane
);
    // Select the placement rule of the active layout.
    always_comb begin
        unique case (lay)
            LAY_SEP: begin
                bank = BANK_W'(img);
                addr = ADDR_W'(idx);
                lane = '0;
            end
            LAY_LANE: begin
                bank = BANK_W'(img >> 2);
                addr = ADDR_W'(idx);
                lane = LANE_W'(img[1:0]);
            end
            LAY_QUAD: begin
                bank = BANK_W'(img);
                addr = ADDR_W'(idx >> 2);
                lane = LANE_W'(idx[1:0]);
            end
            default: begin
                bank = BANK_W'(img >> 1);
                addr = ADDR_W'(idx >> 1);
                lane = LANE_W'({img[0], idx[0]});
            end
        endcase
    end
endmodule

// File: rtl/ppm_wr_pack.sv
// Gathers pixels into a word and issues one masked word write when the
// word is complete or the frame ends. Assumes the caller marks the last
// pixel of each word group and of each frame.
module ppm_wr_pack #(
    parameter int PIX_W  = 8,
    parameter int WORD_W = 32,
    parameter int BANK_W = 3,
    parameter int ADDR_W = 19,
    parameter int LANES  = WORD_W / PIX_W,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_last,
    input  logic              grp_end,
    input  logic [LANE_W-1:0] lane,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output logic              wq_valid,
    output logic [BANK_W-1:0] wq_bank,
    output logic [ADDR_W-1:0] wq_addr,
    output logic [LANES-1:0]  wq_be,
    output logic [WORD_W-1:0] wq_data
);
    logic [WORD_W-1:0] acc_data, mrg_data;
    logic [LANES-1:0]  acc_be, mrg_be;

    // Merge the incoming pixel into the partial word.
    always_comb begin
        mrg_data = acc_data | ({{(WORD_W-PIX_W){1'b0}}, pix_data} << (32'(lane) * PIX_W));
        mrg_be   = acc_be | (LANES'(1) << lane);
    end

    // Hold the partial word and issue it when full or at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_data <= '0;
            acc_be   <= '0;
            wq_valid <= 1'b0;
            wq_bank  <= '0;
            wq_addr  <= '0;
            wq_be    <= '0;
            wq_data  <= '0;
        end else begin
            wq_valid <= 1'b0;
            if (pix_valid) begin
                if (grp_end || pix_last) begin
                    wq_valid <= 1'b1;
                    wq_bank  <= bank;
                    wq_addr  <= addr;
                    wq_be    <= mrg_be;
                    wq_data  <= mrg_data;
                    acc_data <= '0;
                    acc_be   <= '0;
                end else begin
                    acc_data <= mrg_data;
                    acc_be   <= mrg_be;
                end
            end
        end
    end
endmodule

// File: rtl/ppm_rd_unpack.sv
// Issues a word read for a pixel request and selects the pixel's byte
// from the returned word. Assumes memory data arrives one cycle after
// the read is issued.
module ppm_rd_unpack #(
    parameter int PIX_W  = 8,
    parameter int WORD_W = 32,
    parameter int BANK_W = 3,
    parameter int ADDR_W = 19,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] rdata,
    output logic              rq_valid,
    output logic [BANK_W-1:0] rq_bank,
    output logic [ADDR_W-1:0] rq_addr,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix
);
    logic [LANE_W-1:0] lane_iss, lane_rsp;
    logic              rsp_pend;

    // Register the read issue and track the lane until data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_valid <= 1'b0;
            rq_bank  <= '0;
            rq_addr  <= '0;
            lane_iss <= '0;
            lane_rsp <= '0;
            rsp_pend <= 1'b0;
        end else begin
            rq_valid <= req_valid;
            if (req_valid) begin
                rq_bank  <= bank;
                rq_addr  <= addr;
                lane_iss <= lane;
            end
            rsp_pend <= rq_valid;
            lane_rsp <= lane_iss;
        end
    end

    // Pick the pixel out of the returned word.
    always_comb begin
        pix_valid = rsp_pend;
        pix       = rdata[32'(lane_rsp) * PIX_W +: PIX_W];
    end
endmodule

// File: rtl/pix_pack_mapper.sv
// Top of the packed image-buffer mapper: holds the layout, tracks the
// write frame, maps write and read pixels, and counts busy bus cycles.
// Assumes one image per write frame and a one-cycle memory read latency.
module pix_pack_mapper
    import ppm_pkg::*;
#(
    parameter int NUM_IMG   = 5,
    parameter int NUM_BANKS = 5,
    parameter int PIX_W     = 8,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 17,
    parameter int ADDR_W    = 19,
    parameter int CNT_W     = 32,
    localparam int IMG_W    = $clog2(NUM_IMG),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int LANES    = WORD_W / PIX_W,
    localparam int LANE_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_layout,
    output logic              cfg_err,
    input  logic              wr_valid,
    input  logic [IMG_W-1:0]  wr_img,
    input  logic [PIX_W-1:0]  wr_pix,
    input  logic              wr_last,
    output logic              wq_valid,
    output logic [BANK_W-1:0] wq_bank,
    output logic [ADDR_W-1:0] wq_addr,
    output logic [LANES-1:0]  wq_be,
    output logic [WORD_W-1:0] wq_data,
    input  logic              rd_valid,
    input  logic [IMG_W-1:0]  rd_img,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rq_valid,
    output logic [BANK_W-1:0] rq_bank,
    output logic [ADDR_W-1:0] rq_addr,
    input  logic [WORD_W-1:0] rq_rdata,
    output logic              rd_pix_valid,
    output logic [PIX_W-1:0]  rd_pix,
    output logic [CNT_W-1:0]  bus_cycles
);
    layout_e           layout_q;
    logic              in_frame;
    logic [IDX_W-1:0]  pix_idx;
    logic [IMG_W-1:0]  img_q, cur_img;
    logic              grp_end;
    logic [BANK_W-1:0] w_bank, r_bank;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic [LANE_W-1:0] w_lane, r_lane;

    // Image of the current pixel: live on a frame's first pixel, held after.
    assign cur_img = in_frame ? img_q : wr_img;

    // Decide whether the current pixel fills the last lane of its word.
    always_comb begin
        unique case (layout_q)
            LAY_QUAD: grp_end = (pix_idx[1:0] == 2'd3);
            LAY_PAIR: grp_end = pix_idx[0];
            default:  grp_end = 1'b1;
        endcase
    end

    // Accept layout changes only when idle; flag refused requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q <= LAY_SEP;
            cfg_err  <= 1'b0;
        end else if (cfg_we) begin
            if (in_frame || wr_valid) cfg_err <= 1'b1;
            else                      layout_q <= layout_e'(cfg_layout);
        end
    end

    // Track frame progress, pixel index and the frame's image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            pix_idx  <= '0;
            img_q    <= '0;
        end else if (wr_valid) begin
            if (wr_last) begin
                in_frame <= 1'b0;
                pix_idx  <= '0;
            end else begin
                in_frame <= 1'b1;
                pix_idx  <= pix_idx + IDX_W'(1);
                img_q    <= cur_img;
            end
        end
    end

    // Count cycles in which either bus port is active.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bus_cycles <= '0;
        else if (wq_valid || rq_valid) bus_cycles <= bus_cycles + CNT_W'(1);
    end

    ppm_addr_map #(.IMG_W(IMG_W), .BANK_W(BANK_W), .IDX_W(IDX_W),
                   .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_wmap (
        .lay(layout_q), .img(cur_img), .idx(pix_idx),
        .bank(w_bank), .addr(w_addr), .lane(w_lane)
    );

    ppm_addr_map #(.IMG_W(IMG_W), .BANK_W(BANK_W), .IDX_W(IDX_W),
                   .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rmap (
        .lay(layout_q), .img(rd_img), .idx(rd_idx),
        .bank(r_bank), .addr(r_addr), .lane(r_lane)
    );

    ppm_wr_pack #(.PIX_W(PIX_W), .WORD_W(WORD_W), .BANK_W(BANK_W),
                  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wpack (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(wr_valid), .pix_data(wr_pix), .pix_last(wr_last),
        .grp_end(grp_end), .lane(w_lane), .bank(w_bank), .addr(w_addr),
        .wq_valid(wq_valid), .wq_bank(wq_bank), .wq_addr(wq_addr),
        .wq_be(wq_be), .wq_data(wq_data)
    );

    ppm_rd_unpack #(.PIX_W(PIX_W), .WORD_W(WORD_W), .BANK_W(BANK_W),
                    .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rpack (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rd_valid), .bank(r_bank), .addr(r_addr), .lane(r_lane),
        .rdata(rq_rdata),
        .rq_valid(rq_valid), .rq_bank(rq_bank), .rq_addr(rq_addr),
        .pix_valid(rd_pix_valid), .pix(rd_pix)
    );
endmodule

// File: rtl/ppm_chk.sv
// Assertion checker for pix_pack_mapper, attached by bind. Assumes the
// layout codes of ppm_pkg and four byte lanes per word.
module ppm_chk
    import ppm_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 3,
    parameter int LANES     = 4,
    parameter int CNT_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_frame,
    input logic              wr_valid,
    input layout_e           layout_q,
    input logic              cfg_err,
    input logic              wq_valid,
    input logic [BANK_W-1:0] wq_bank,
    input logic [LANES-1:0]  wq_be,
    input logic              rq_valid,
    input logic              rd_pix_valid,
    input logic [CNT_W-1:0]  bus_cycles
);
    // R10: layout frozen while a frame or pixel is in flight.
    p_layout_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame || wr_valid) |=> $stable(layout_q));

    // R10: refused-change flag never clears.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R6: issued writes carry enables and address a real bank.
    p_wr_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wq_valid |-> (wq_be != '0) && (32'(wq_bank) < NUM_BANKS));

    // R1, R2: single-lane layouts enable exactly one lane.
    p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wq_valid && (layout_q == LAY_SEP || layout_q == LAY_LANE))
            |-> $countones(wq_be) == 1);

    // R4: paired layout keeps writes within one half of the word.
    p_pair_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wq_valid && layout_q == LAY_PAIR)
            |-> (wq_be[LANES-1:LANES/2] == '0) || (wq_be[LANES/2-1:0] == '0));

    // R7: every read issue yields a returned pixel next cycle.
    p_read_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> rd_pix_valid);

    // R8: counter steps by one on busy cycles and holds otherwise.
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wq_valid || rq_valid) |=> bus_cycles == $past(bus_cycles) + CNT_W'(1));
    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wq_valid || rq_valid) |=> $stable(bus_cycles));
endmodule

bind pix_pack_mapper ppm_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .LANES(LANES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .wr_valid(wr_valid),
    .layout_q(layout_q), .cfg_err(cfg_err), .wq_valid(wq_valid),
    .wq_bank(wq_bank), .wq_be(wq_be), .rq_valid(rq_valid),
    .rd_pix_valid(rd_pix_valid), .bus_cycles(bus_cycles)
);

// File: tb/tb_pix_pack_mapper.sv
// Directed bench for pix_pack_mapper with a small behavioural memory.
module tb_pix_pack_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_layout = '0;
    logic        cfg_err;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_img = '0;
    logic [7:0]  wr_pix = '0;
    logic        wr_last = 1'b0;
    logic        wq_valid;
    logic [2:0]  wq_bank;
    logic [18:0] wq_addr;
    logic [3:0]  wq_be;
    logic [31:0] wq_data;
    logic        rd_valid = 1'b0;
    logic [2:0]  rd_img = '0;
    logic [16:0] rd_idx = '0;
    logic        rq_valid;
    logic [2:0]  rq_bank;
    logic [18:0] rq_addr;
    logic [31:0] rq_rdata = '0;
    logic        rd_pix_valid;
    logic [7:0]  rd_pix;
    logic [31:0] bus_cycles;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mem [0:7][0:15];

    always #5 clk = ~clk;

    pix_pack_mapper dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_layout(cfg_layout),
        .cfg_err(cfg_err), .wr_valid(wr_valid), .wr_img(wr_img),
        .wr_pix(wr_pix), .wr_last(wr_last), .wq_valid(wq_valid),
        .wq_bank(wq_bank), .wq_addr(wq_addr), .wq_be(wq_be),
        .wq_data(wq_data), .rd_valid(rd_valid), .rd_img(rd_img),
        .rd_idx(rd_idx), .rq_valid(rq_valid), .rq_bank(rq_bank),
        .rq_addr(rq_addr), .rq_rdata(rq_rdata), .rd_pix_valid(rd_pix_valid),
        .rd_pix(rd_pix), .bus_cycles(bus_cycles)
    );

    // Behavioural banks: masked writes, one-cycle read latency.
    always @(posedge clk) begin
        if (wq_valid)
            for (int b = 0; b < 4; b++)
                if (wq_be[b]) mem[wq_bank][wq_addr[3:0]][b*8 +: 8] <= wq_data[b*8 +: 8];
        if (rq_valid) rq_rdata <= mem[rq_bank][rq_addr[3:0]];
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] img, input logic [7:0] d, input bit last);
        @(negedge clk);
        wr_valid = 1'b1; wr_img = img; wr_pix = d; wr_last = last;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic expect_wr(input string tag, input logic v, input logic [2:0] bank,
                             input logic [18:0] addr, input logic [3:0] be,
                             input logic [31:0] data);
        check({tag, " valid"}, wq_valid, v);
        if (v) check({tag, " word"}, {wq_bank, wq_addr, wq_be, wq_data},
                     {bank, addr, be, data});
    endtask

    task automatic set_layout(input logic [1:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_layout = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_pix(input string tag, input logic [2:0] img, input logic [16:0] idx,
                            input logic [2:0] bank, input logic [18:0] addr,
                            input logic [7:0] exp);
        @(negedge clk);
        rd_valid = 1'b1; rd_img = img; rd_idx = idx;
        @(negedge clk);
        rd_valid = 1'b0;
        check({tag, " issue"}, {rq_valid, rq_bank, rq_addr}, {1'b1, bank, addr});
        @(negedge clk);
        check({tag, " pixel"}, {rd_pix_valid, rd_pix}, {1'b1, exp});
    endtask

    task automatic t_reset();
        check("R11 reset outputs", {wq_valid, rq_valid, rd_pix_valid, cfg_err}, 4'b0);
        check("R11 reset count", bus_cycles, 0);
    endtask

    // R1 and R9 default: layout 0 after reset.
    task automatic t_sep();
        push(3'd2, 8'h11, 1'b0); expect_wr("R1 n0", 1, 3'd2, 0, 4'b0001, 32'h11);
        push(3'd2, 8'h22, 1'b0); expect_wr("R1 n1", 1, 3'd2, 1, 4'b0001, 32'h22);
        push(3'd2, 8'h33, 1'b1); expect_wr("R1 n2", 1, 3'd2, 2, 4'b0001, 32'h33);
        read_pix("R1 read", 3'd2, 17'd1, 3'd2, 19'd1, 8'h22);
    endtask

    // R2 with R9 accepted change.
    task automatic t_lane();
        set_layout(2'd1);
        check("R9 no error", cfg_err, 0);
        push(3'd1, 8'hA5, 1'b1); expect_wr("R2 img1", 1, 3'd0, 0, 4'b0010, 32'h0000A500);
        push(3'd4, 8'h3C, 1'b1); expect_wr("R2 img4", 1, 3'd1, 0, 4'b0001, 32'h0000003C);
        push(3'd3, 8'h01, 1'b0); expect_wr("R2 img3 n0", 1, 3'd0, 0, 4'b1000, 32'h01000000);
        push(3'd3, 8'h02, 1'b1); expect_wr("R2 img3 n1", 1, 3'd0, 1, 4'b1000, 32'h02000000);
        read_pix("R2 read", 3'd1, 17'd0, 3'd0, 19'd0, 8'hA5);
    endtask

    // R3, R5, R6 and R8.
    task automatic t_quad();
        logic [31:0] c0;
        set_layout(2'd2);
        repeat (2) @(negedge clk);
        c0 = bus_cycles;
        push(3'd3, 8'hA0, 1'b0); expect_wr("R6 hold n0", 0, 0, 0, 0, 0);
        push(3'd3, 8'hA1, 1'b0); expect_wr("R6 hold n1", 0, 0, 0, 0, 0);
        push(3'd3, 8'hA2, 1'b0); expect_wr("R6 hold n2", 0, 0, 0, 0, 0);
        push(3'd3, 8'hA3, 1'b0); expect_wr("R3 full", 1, 3'd3, 0, 4'b1111, 32'hA3A2A1A0);
        @(negedge clk);
        check("R6 single cycle", wq_valid, 0);
        push(3'd3, 8'hA4, 1'b0); expect_wr("R6 hold n4", 0, 0, 0, 0, 0);
        push(3'd3, 8'hA5, 1'b1); expect_wr("R5 partial", 1, 3'd3, 1, 4'b0011, 32'h0000A5A4);
        read_pix("R3 read", 3'd3, 17'd5, 3'd3, 19'd1, 8'hA5);
        check("R8 count", bus_cycles - c0, 3);
    endtask

    // R4 and R5 for the paired layout.
    task automatic t_pair();
        set_layout(2'd3);
        push(3'd3, 8'hB0, 1'b0); expect_wr("R4 hold", 0, 0, 0, 0, 0);
        push(3'd3, 8'hB1, 1'b0); expect_wr("R4 word", 1, 3'd1, 0, 4'b1100, 32'hB1B00000);
        push(3'd3, 8'hB2, 1'b1); expect_wr("R5 pair tail", 1, 3'd1, 1, 4'b0100, 32'h00B20000);
        read_pix("R4 read", 3'd3, 17'd1, 3'd1, 19'd0, 8'hB1);
    endtask

    // R10: refused change mid-frame, mapping unchanged, flag sticky.
    task automatic t_refuse();
        push(3'd0, 8'hC0, 1'b0);
        set_layout(2'd0);
        check("R10 error set", cfg_err, 1);
        push(3'd0, 8'hC1, 1'b1); expect_wr("R10 still pair", 1, 3'd0, 0, 4'b0011, 32'h0000C1C0);
        set_layout(2'd2);
        push(3'd0, 8'hC7, 1'b1); expect_wr("R9 quad applied", 1, 3'd0, 0, 4'b0001, 32'h000000C7);
        check("R10 sticky", cfg_err, 1);
    endtask

    // R8: a write issue and a read issue in the same cycle count once.
    task automatic t_overlap();
        logic [31:0] c0;
        repeat (2) @(negedge clk);
        c0 = bus_cycles;
        @(negedge clk);
        wr_valid = 1'b1; wr_img = 3'd4; wr_pix = 8'hD4; wr_last = 1'b1;
        rd_valid = 1'b1; rd_img = 3'd3; rd_idx = 17'd0;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0; rd_valid = 1'b0;
        check("R8 both ports", {wq_valid, rq_valid}, 2'b11);
        @(negedge clk);
        check("R8 overlap counted once", bus_cycles - c0, 1);
    endtask

    initial begin
        for (int b = 0; b < 8; b++)
            for (int a = 0; a < 16; a++) mem[b][a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sep();
        t_lane();
        t_quad();
        t_pair();
        t_refuse();
        t_overlap();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule